// File: doc/BRIEF.md
# Address-Sequence Bank Select Controller

This block sits beside a processor's address bus and turns particular patterns of read or write offsets into a 2-bit bank number. The bank number drives two page-select pins, for example to choose one of four video-memory pages. Software never writes a register. It changes the bank only by touching chosen word offsets in the right order while the block's chip-select is asserted. The offsets and masks that must be matched are parameters, so one module can stand in for several differently keyed variants of the same protection scheme.

Three routes can change the bank. An access at offset zero re-arms the machine. In the direct route, the next access picks one of four fixed offsets, and that offset loads the bank. In the bitwise route, an entry offset opens a window. Inside the window, four masked offsets each clear or set one bank bit, and a closing offset shuts the window. In the alternate route, four masked compares follow one another. The bank value is taken from the third access of that chain and applied on the fourth. Any access that fits none of these patterns drops the machine to an idle state. In the idle state only a new zero access is recognised.

Top module: `bank_seq_ctrl`

## Requirements
- R1: After reset, bank_o is 3 and state_o is 1 (ENABLED).
- R2: A qualified access at word offset 0 puts state_o at 1 (ENABLED) from every state and leaves bank_o unchanged.
- R3: In ENABLED, an access whose offset exactly equals select offset k (defaults 0x10, 0x14, 0x18, 0x1C for k = 0..3) sets bank_o to k and state_o to 0 (DISABLED).
- R4: In ENABLED, an access with (offset & 0x3FF0) == 0x35B0 moves state_o to 2 (BITWISE1) and leaves bank_o unchanged.
- R5: In BITWISE1 or BITWISE2, an access with (offset & 0x3FF3) equal to 0x35B0, 0x35B1, 0x35B2 or 0x35B3 respectively clears bank bit 0, sets bit 0, clears bit 1 or sets bit 1. It then leaves state_o at 3 (BITWISE2).
- R6: In BITWISE2, an access with (offset & 0x3FF8) == 0x35C0 sets state_o to 0 (DISABLED) and leaves bank_o unchanged.
- R7: The alternate chain passes through state_o 4, 5 and 6 (ALT1..ALT3). Step 1 matches (offset & 0x007F) == 0x3D from ENABLED. Step 2 matches (offset & 0x3FFF) == 0x92. Step 3 matches (offset & 0x3FFC) == 0xA4 and records offset bits [1:0] (shift 0). Step 4 matches (offset & 0x3FF3) == 0x10, loads the recorded value into bank_o and sets state_o to 0. Before step 4, bank_o does not change.
- R8: A nonzero access that matches nothing expected in the current state sets state_o to 0 and leaves bank_o unchanged. In DISABLED, every nonzero access is ignored.
- R9: An access counts only when cs_i and req_i are both high. It counts once per rising edge of their conjunction, however many cycles they stay high.
- R10: State and bank change only in the clock edge that ends a counted access, and are visible on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip-select qualifying the access |
| req_i | input | 1 | Access request, may be held for several cycles |
| addr_i | input | 14 | Word offset of the access |
| bank_o | output | 2 | Bank number driving the two page-select pins |
| state_o | output | 3 | Sequencer state: 0 DISABLED, 1 ENABLED, 2 BITWISE1, 3 BITWISE2, 4..6 ALT1..ALT3 |

## Verification
If the sequencer is in the wrong state, the next access is mis-decoded. That error reaches the ports on the cycle after that access. It shows either as a bank change that should not have happened or as a missing one. It also shows as a wrong state_o code, so the bench checks both outputs after every access rather than only at the end of a sequence. A request that is counted twice moves the bitwise entry on into BITWISE2 on the second count, so holding that access for several cycles exposes double counting at once. A swapped set/clear decode turns up on the first bitwise step, because the bench walks the bank through all four values.

// File: rtl/bank_seq_pkg.sv
package bank_seq_pkg;
  typedef enum logic [2:0] {
    ST_DIS  = 3'd0,
    ST_EN   = 3'd1,
    ST_BW1  = 3'd2,
    ST_BW2  = 3'd3,
    ST_ALT1 = 3'd4,
    ST_ALT2 = 3'd5,
    ST_ALT3 = 3'd6
  } seq_state_e;

  typedef struct packed {
    logic       zero;
    logic       sel_hit;
    logic [1:0] sel_idx;
    logic [3:0] alt_hit;
    logic [1:0] alt_val;
    logic       bw_enter;
    logic       bw_op_hit;
    logic [1:0] bw_op;
    logic       bw_final;
  } match_t;
endpackage

// File: rtl/bank_seq_qual.sv
module bank_seq_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic req_i,
  output logic pulse_o
);
  logic live, live_q;
  assign live = cs_i & req_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= live;

  assign pulse_o = live & ~live_q;

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/bank_seq_match.sv
module bank_seq_match
  import bank_seq_pkg::*;
#(
  parameter int AW = 14,
  parameter logic [3:0][AW-1:0] SEL_OFFS = {14'h001C, 14'h0018, 14'h0014, 14'h0010},
  parameter logic [3:0][AW-1:0] ALT_MASK = {14'h3FF3, 14'h3FFC, 14'h3FFF, 14'h007F},
  parameter logic [3:0][AW-1:0] ALT_VAL  = {14'h0010, 14'h00A4, 14'h0092, 14'h003D},
  parameter int ALT_SHIFT = 0,
  parameter logic [AW-1:0] BW_ENT_MASK = 14'h3FF0,
  parameter logic [AW-1:0] BW_BASE     = 14'h35B0,
  parameter logic [AW-1:0] BW_OP_MASK  = 14'h3FF3,
  parameter logic [AW-1:0] BW_FIN_MASK = 14'h3FF8,
  parameter logic [AW-1:0] BW_FIN_VAL  = 14'h35C0
) (
  input  logic [AW-1:0] addr_i,
  output match_t        m_o
);
  localparam int NSEL = 4;
  logic [NSEL-1:0] sel_eq, op_eq;
  logic [AW-1:0]   shifted;

  for (genvar k = 0; k < NSEL; k++) begin : g_cmp
    localparam logic [AW-1:0] OP_VAL = BW_BASE + AW'(k);
    assign sel_eq[k]     = (addr_i == SEL_OFFS[k]);
    assign op_eq[k]      = ((addr_i & BW_OP_MASK) == OP_VAL);
    assign m_o.alt_hit[k] = ((addr_i & ALT_MASK[k]) == ALT_VAL[k]);
  end

  always_comb begin
    m_o.sel_idx = 2'd0;
    m_o.bw_op   = 2'd0;
    for (int k = NSEL - 1; k >= 0; k--) begin
      if (sel_eq[k]) m_o.sel_idx = 2'(k);
      if (op_eq[k])  m_o.bw_op   = 2'(k);
    end
  end

  assign shifted      = addr_i >> ALT_SHIFT;
  assign m_o.alt_val  = shifted[1:0];
  assign m_o.zero     = (addr_i == '0);
  assign m_o.sel_hit  = |sel_eq;
  assign m_o.bw_op_hit = |op_eq;
  assign m_o.bw_enter = ((addr_i & BW_ENT_MASK) == BW_BASE);
  assign m_o.bw_final = ((addr_i & BW_FIN_MASK) == BW_FIN_VAL);
endmodule

// File: rtl/bank_seq_fsm.sv
module bank_seq_fsm
  import bank_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       acc_i,
  input  match_t     m_i,
  output logic [1:0] bank_o,
  output seq_state_e state_o
);
  seq_state_e st_q, st_d;
  logic [1:0] bank_q, bank_d, alt_q, alt_d;

  always_comb begin
    st_d   = st_q;
    bank_d = bank_q;
    alt_d  = alt_q;
    if (acc_i) begin
      if (m_i.zero) st_d = ST_EN;
      else begin
        unique case (st_q)
          ST_DIS: st_d = ST_DIS;
          ST_EN: begin
            if (m_i.sel_hit) begin
              bank_d = m_i.sel_idx;
              st_d   = ST_DIS;
            end else if (m_i.alt_hit[0]) st_d = ST_ALT1;
            else if (m_i.bw_enter)       st_d = ST_BW1;
            else                         st_d = ST_DIS;
          end
          ST_BW1, ST_BW2: begin
            if (st_q == ST_BW2 && m_i.bw_final) st_d = ST_DIS;
            else if (m_i.bw_op_hit) begin
              bank_d[m_i.bw_op[1]] = m_i.bw_op[0];
              st_d = ST_BW2;
            end else st_d = ST_DIS;
          end
          ST_ALT1: st_d = m_i.alt_hit[1] ? ST_ALT2 : ST_DIS;
          ST_ALT2: begin
            if (m_i.alt_hit[2]) begin
              alt_d = m_i.alt_val;
              st_d  = ST_ALT3;
            end else st_d = ST_DIS;
          end
          ST_ALT3: begin
            if (m_i.alt_hit[3]) bank_d = alt_q;
            st_d = ST_DIS;
          end
          default: st_d = ST_DIS;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q   <= ST_EN;
      bank_q <= 2'd3;
      alt_q  <= 2'd0;
    end else begin
      st_q   <= st_d;
      bank_q <= bank_d;
      alt_q  <= alt_d;
    end

  assign bank_o  = bank_q;
  assign state_o = st_q;

  a_r2_zero_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && m_i.zero |=> st_q == ST_EN && $stable(bank_q));
  a_r10_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> $stable(bank_q) && $stable(st_q));
  a_r8_disabled_ignores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && !m_i.zero && st_q == ST_DIS |=> st_q == ST_DIS && $stable(bank_q));
  a_r5_one_bit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && (st_q == ST_BW1 || st_q == ST_BW2) |=> $countones(bank_q ^ $past(bank_q)) <= 1);
  a_r7_alt_bank_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && (st_q == ST_ALT1 || st_q == ST_ALT2) |=> $stable(bank_q));
endmodule

// File: rtl/bank_seq_ctrl.sv
module bank_seq_ctrl
  import bank_seq_pkg::*;
#(
  parameter int AW = 14,
  parameter logic [3:0][AW-1:0] SEL_OFFS = {14'h001C, 14'h0018, 14'h0014, 14'h0010},
  parameter logic [3:0][AW-1:0] ALT_MASK = {14'h3FF3, 14'h3FFC, 14'h3FFF, 14'h007F},
  parameter logic [3:0][AW-1:0] ALT_VAL  = {14'h0010, 14'h00A4, 14'h0092, 14'h003D},
  parameter int ALT_SHIFT = 0,
  parameter logic [AW-1:0] BW_ENT_MASK = 14'h3FF0,
  parameter logic [AW-1:0] BW_BASE     = 14'h35B0,
  parameter logic [AW-1:0] BW_OP_MASK  = 14'h3FF3,
  parameter logic [AW-1:0] BW_FIN_MASK = 14'h3FF8,
  parameter logic [AW-1:0] BW_FIN_VAL  = 14'h35C0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  output logic [1:0]    bank_o,
  output logic [2:0]    state_o
);
  logic       acc;
  match_t     m;
  seq_state_e st;

  bank_seq_qual u_qual (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .req_i(req_i), .pulse_o(acc)
  );

  bank_seq_match #(
    .AW(AW), .SEL_OFFS(SEL_OFFS), .ALT_MASK(ALT_MASK), .ALT_VAL(ALT_VAL),
    .ALT_SHIFT(ALT_SHIFT), .BW_ENT_MASK(BW_ENT_MASK), .BW_BASE(BW_BASE),
    .BW_OP_MASK(BW_OP_MASK), .BW_FIN_MASK(BW_FIN_MASK), .BW_FIN_VAL(BW_FIN_VAL)
  ) u_match (
    .addr_i(addr_i), .m_o(m)
  );

  bank_seq_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc), .m_i(m),
    .bank_o(bank_o), .state_o(st)
  );

  assign state_o = st;
endmodule

// File: tb/bank_seq_ctrl_test.sv
module bank_seq_ctrl_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_i = 1'b0;
  logic        req_i = 1'b0;
  logic [13:0] addr_i = '0;
  logic [1:0]  bank_o;
  logic [2:0]  state_o;
  int checks = 0;
  int fails = 0;

  bank_seq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs_i), .req_i(req_i),
    .addr_i(addr_i), .bank_o(bank_o), .state_o(state_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [1:0] eb, input logic [2:0] es);
    checks++;
    if (bank_o !== eb || state_o !== es) begin
      fails++;
      $display("FAIL %s: bank=%0d state=%0d expected bank=%0d state=%0d",
               tag, bank_o, state_o, eb, es);
    end
  endtask

  // drive at negedge, hold for n cycles, then one idle cycle; sampled at a negedge
  task automatic acc(input logic [13:0] a, input int n = 1, input logic cs = 1'b1);
    addr_i = a; cs_i = cs; req_i = 1'b1;
    repeat (n) @(negedge clk);
    req_i = 1'b0; cs_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reset", 2'd3, 3'd1);
  endtask

  task automatic t_simple();
    acc(14'h0014); check("R3 select 1", 2'd1, 3'd0);
    acc(14'h001C); check("R8 disabled ignores", 2'd1, 3'd0);
    acc(14'h0000); check("R2 zero arms", 2'd1, 3'd1);
    acc(14'h0010); check("R3 select 0", 2'd0, 3'd0);
    acc(14'h0000); acc(14'h0018); check("R3 select 2", 2'd2, 3'd0);
    acc(14'h0000); acc(14'h001C); check("R3 select 3", 2'd3, 3'd0);
    acc(14'h0000); acc(14'h0055); check("R8 mismatch", 2'd3, 3'd0);
  endtask

  task automatic t_bitwise();
    acc(14'h0000); acc(14'h35B0); check("R4 enter", 2'd3, 3'd2);
    acc(14'h35B0); check("R5 clear b0", 2'd2, 3'd3);
    acc(14'h35B1); check("R5 set b0", 2'd3, 3'd3);
    acc(14'h35B2); check("R5 clear b1", 2'd1, 3'd3);
    acc(14'h35B4); check("R5 masked clear b0", 2'd0, 3'd3);
    acc(14'h35B3); check("R5 set b1", 2'd2, 3'd3);
    acc(14'h35C0); check("R6 final", 2'd2, 3'd0);
    acc(14'h0000); acc(14'h35B5); acc(14'h1234);
    check("R8 bitwise mismatch", 2'd2, 3'd0);
  endtask

  task automatic t_alt();
    acc(14'h0000); acc(14'h013D); check("R7 step1 masked", 2'd2, 3'd4);
    acc(14'h0092); check("R7 step2", 2'd2, 3'd5);
    acc(14'h00A5); check("R7 step3 no load yet", 2'd2, 3'd6);
    acc(14'h0014); check("R7 step4 loads", 2'd1, 3'd0);
    acc(14'h0000); acc(14'h003D); acc(14'h0093);
    check("R8 alt mismatch", 2'd1, 3'd0);
    acc(14'h0000); acc(14'h003D); acc(14'h0000);
    check("R2 zero from alt", 2'd1, 3'd1);
  endtask

  task automatic t_qualify();
    acc(14'h0014, 1, 1'b0); check("R9 no cs ignored", 2'd1, 3'd1);
    acc(14'h35B0, 4); check("R9 held counts once", 2'd1, 3'd2);
    addr_i = 14'h0010; cs_i = 1'b1; req_i = 1'b1;
    @(negedge clk); check("R10 change next cycle", 2'd1, 3'd0);
    req_i = 1'b0; cs_i = 1'b0; @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        t_reset();
        t_simple();
        t_bitwise();
        t_alt();
        t_qualify();
        rst_ni = 1'b0; @(negedge clk); rst_ni = 1'b1; @(negedge clk);
        check("R1 reset again", 2'd3, 3'd1);
      end
      begin
        repeat (5000) @(negedge clk);
        fails++; checks++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule